// File: doc/BRIEF.md
# Quad DAC SPI register interface

This block is the digital command port of a four-channel output converter. A host talks to it over a mode-0 SPI link in 24-bit frames. Each frame is either a write, which lands in one of the per-channel data, gain, offset or control registers or in one of two shared configuration words, or a read, whose answer comes back in the low half of the following frame. A fixed no-op frame is the usual way to clock that answer out. The SPI pins are sampled in the system clock domain, so the system clock must run well above the serial clock.

Each channel's live data code and control word are driven on parallel outputs, together with a flag for channels set to a current range, so the analog stage next to this block can use them directly. SPI has no flow control. The host paces the frames and keeps chip select high between frames for at least `SYNC_STAGES + 3` system clocks. A frame is acted on only when chip select rises.

Top module: `qdac_spi_regs`

## Requirements
- R1: A frame is 24 bits shifted MSB first in SPI mode 0: MOSI is sampled on SCLK rising edges, and MISO changes after falling edges. Bit 23 is the read flag, bits 20:16 are the address, bits 15:0 are the data, and the frame takes effect when chip select rises.
- R2: A frame with 23, 25 or any other number of clocks other than 24 changes no register, and it leaves the pending read value as it was.
- R3: Writes with bit 23 clear use addresses 0x00-0x03 for the data code, 0x08-0x0B for gain and 0x10-0x13 for offset, with address bits 1:0 selecting the channel. Writes to 0x04-0x07, 0x0C-0x0F and 0x14-0x1B change nothing.
- R4: Writes to 0x1C-0x1F take their selector from data bits 15:13. Selector 0 stores bits 12:0 as the channel's slew word. Selector 2 stores bits 8:0 as the channel's DAC control word. Selector 1 stores bits 12:0 in the shared main word, and selector 3 stores bits 6:0 in the shared DC-DC word, whatever the channel bits hold. Selectors 4 to 7 store nothing.
- R5: The frame 0x1CE000 is a no-op and changes no register.
- R6: Reads, with bit 23 set, use address 0x00-0x03 for data, 0x04-0x07 for the DAC control word, 0x08-0x0B for gain, 0x0C-0x0F for offset, 0x10-0x13 for clear code, 0x14-0x17 for slew, 0x18 for status, 0x19 for main and 0x1A for DC-DC. A read frame writes nothing.
- R7: The value a read frame addresses comes back in bits 15:0 of the next 24-bit frame, and bits 23:16 of that frame are zero. After any accepted frame that is not a read, the next frame returns zero.
- R8: Clear-code reads and reads of 0x1B-0x1F return zero. Status bit i is the output-enable bit (bit 6) of channel i's DAC control word, and status bits 15:4 are zero.
- R9: After reset, data, gain, slew, control, main and DC-DC are zero and every offset register holds 0x8000.
- R10: dac_code_o[16i+15:16i] and dac_ctrl_o[9i+8:9i] carry channel i's data code and DAC control word. ch_current_o[i] is high exactly when the control word's range field (bits 2:0) is 4, 5 or 6.
- R11: MISO is low while chip select is high.
- R12: main_cfg_o and dcdc_cfg_o carry the shared main and DC-DC words. In the DC-DC word, bits 1:0 are the maximum voltage, bits 3:2 the frequency code, bits 5:4 the phase mode and bit 6 the external compensation select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| dac_code_o | output | 64 | Data codes of the four channels |
| dac_ctrl_o | output | 36 | DAC control words of the four channels |
| ch_current_o | output | 4 | Channel i is set to a current range |
| main_cfg_o | output | 13 | Shared main word |
| dcdc_cfg_o | output | 7 | Shared DC-DC word |

## Verification
With the default two-stage synchronizer, a frame's writes reach the parallel outputs four system clocks after chip select rises. The read value is staged in the same cycle, and it appears on MISO three clocks after chip select falls in the next frame. The bench drives each SCLK phase for six system clocks and leaves chip select high for ten clocks after a frame before it compares outputs. It samples MISO on its own SCLK rising edges, so every value is read well after its update. Every frame is checked against a model in the bench: the echoed read value, all parallel outputs and idle MISO. This covers sweeps over every write address, every control selector on every channel, every read address and every range code.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH    = 4;
  localparam int CHW    = 2;
  localparam int DW     = 16;
  localparam int FW     = 24;
  localparam int AW     = 5;
  localparam int SLEWW  = 13;
  localparam int CTRLW  = 9;
  localparam int MAINW  = 13;
  localparam int DCDCW  = 7;
  localparam int RD_BIT = 23;
  localparam int ADDR_LSB = 16;
  localparam int SEL_LSB  = 13;
  localparam int OUT_EN_BIT = 6;

  localparam logic [2:0] RANGE_CUR_LO = 3'd4;
  localparam logic [2:0] RANGE_CUR_HI = 3'd6;

  // write groups, address bits 4:2
  localparam logic [2:0] WGRP_DATA = 3'd0;
  localparam logic [2:0] WGRP_GAIN = 3'd2;
  localparam logic [2:0] WGRP_OFFS = 3'd4;
  localparam logic [2:0] WGRP_CTRL = 3'd7;

  // read groups, address bits 4:2
  localparam logic [2:0] RGRP_DATA   = 3'd0;
  localparam logic [2:0] RGRP_CTRL   = 3'd1;
  localparam logic [2:0] RGRP_GAIN   = 3'd2;
  localparam logic [2:0] RGRP_OFFS   = 3'd3;
  localparam logic [2:0] RGRP_CLEAR  = 3'd4;
  localparam logic [2:0] RGRP_SLEW   = 3'd5;
  localparam logic [2:0] RGRP_SHARED = 3'd6;

  localparam logic [FW-1:0] NOOP_FRAME = 24'h1CE000;

  typedef enum logic [2:0] {
    SUB_SLEW = 3'd0,
    SUB_MAIN = 3'd1,
    SUB_DAC  = 3'd2,
    SUB_DCDC = 3'd3,
    SUB_SOFT = 3'd4
  } ctrl_sub_e;
endpackage

// File: rtl/qdac_spi_shifter.sv
module qdac_spi_shifter #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_W     = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               cs_n_i,
  input  logic               mosi_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic               miso_o,
  output logic               cs_idle_o,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic s_sclk, s_cs, s_mosi;
  logic sclk_d, cs_d;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]   cnt_q;

  // pin synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
    end
  end

  assign s_sclk = sclk_sync[SYNC_STAGES-1];
  assign s_cs   = cs_sync[SYNC_STAGES-1];
  assign s_mosi = mosi_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= s_sclk;
      cs_d   <= s_cs;
    end
  end

  assign sclk_rise = s_sclk & ~sclk_d;
  assign sclk_fall = ~s_sclk & sclk_d;
  assign cs_rise   = s_cs & ~cs_d;
  assign cs_fall   = ~s_cs & cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q        <= '0;
      tx_q        <= '0;
      cnt_q       <= '0;
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      frame_vld_o <= 1'b0;
      if (cs_fall) begin
        cnt_q <= '0;
        tx_q  <= tx_word_i;
      end else if (!s_cs) begin
        if (sclk_rise) begin
          rx_q <= {rx_q[FRAME_W-2:0], s_mosi};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
      if (cs_rise) begin
        frame_vld_o <= (cnt_q == CNT_FULL);
        frame_o     <= rx_q;
      end
    end
  end

  assign cs_idle_o = cs_d;
  assign miso_o    = ~cs_d & tx_q[FRAME_W-1];
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
#(
  parameter logic [DW-1:0] OFFSET_RST = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_data_i,
  input  logic             we_gain_i,
  input  logic             we_offs_i,
  input  logic             we_slew_i,
  input  logic             we_ctrl_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    data_o,
  output logic [DW-1:0]    gain_o,
  output logic [DW-1:0]    offs_o,
  output logic [SLEWW-1:0] slew_o,
  output logic [CTRLW-1:0] ctrl_o,
  output logic             current_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      gain_o <= '0;
      offs_o <= OFFSET_RST;
      slew_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (we_data_i) data_o <= wdata_i;
      if (we_gain_i) gain_o <= wdata_i;
      if (we_offs_i) offs_o <= wdata_i;
      if (we_slew_i) slew_o <= wdata_i[SLEWW-1:0];
      if (we_ctrl_i) ctrl_o <= wdata_i[CTRLW-1:0];
    end
  end

  assign current_o = (ctrl_o[2:0] >= RANGE_CUR_LO) && (ctrl_o[2:0] <= RANGE_CUR_HI);
endmodule

// File: rtl/qdac_readback.sv
module qdac_readback
  import qdac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_vld_i,
  input  logic                 frame_rd_i,
  input  logic [AW-1:0]        frame_addr_i,
  input  logic [NCH*DW-1:0]    data_all_i,
  input  logic [NCH*DW-1:0]    gain_all_i,
  input  logic [NCH*DW-1:0]    offs_all_i,
  input  logic [NCH*SLEWW-1:0] slew_all_i,
  input  logic [NCH*CTRLW-1:0] ctrl_all_i,
  input  logic [MAINW-1:0]     main_i,
  input  logic [DCDCW-1:0]     dcdc_i,
  output logic [FW-1:0]        tx_word_o
);
  logic [DW-1:0] status_w, rd_val, staged_q;
  int rd_ch;

  always_comb begin
    status_w = '0;
    for (int i = 0; i < NCH; i++) status_w[i] = ctrl_all_i[i*CTRLW + OUT_EN_BIT];
  end

  always_comb begin
    rd_ch  = int'(frame_addr_i[CHW-1:0]);
    rd_val = '0;
    case (frame_addr_i[AW-1:CHW])
      RGRP_DATA: rd_val = data_all_i[rd_ch*DW +: DW];
      RGRP_CTRL: rd_val = DW'(ctrl_all_i[rd_ch*CTRLW +: CTRLW]);
      RGRP_GAIN: rd_val = gain_all_i[rd_ch*DW +: DW];
      RGRP_OFFS: rd_val = offs_all_i[rd_ch*DW +: DW];
      RGRP_SLEW: rd_val = DW'(slew_all_i[rd_ch*SLEWW +: SLEWW]);
      RGRP_SHARED: begin
        case (frame_addr_i[CHW-1:0])
          2'd0:    rd_val = status_w;
          2'd1:    rd_val = DW'(main_i);
          2'd2:    rd_val = DW'(dcdc_i);
          default: rd_val = '0;
        endcase
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) staged_q <= '0;
    else if (frame_vld_i) staged_q <= frame_rd_i ? rd_val : '0;
  end

  assign tx_word_o = {{(FW-DW){1'b0}}, staged_q};
endmodule

// File: rtl/qdac_spi_regs.sv
module qdac_spi_regs
  import qdac_pkg::*;
#(
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] OFFSET_RST  = 16'h8000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  output logic [NCH*DW-1:0]    dac_code_o,
  output logic [NCH*CTRLW-1:0] dac_ctrl_o,
  output logic [NCH-1:0]       ch_current_o,
  output logic [MAINW-1:0]     main_cfg_o,
  output logic [DCDCW-1:0]     dcdc_cfg_o
);
  logic          frame_vld, cs_idle;
  logic [FW-1:0] frame_bits, tx_word;
  logic          f_rd, wr_ok;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_data;
  logic [2:0]    f_grp;
  logic [CHW-1:0] f_ch;
  ctrl_sub_e     f_sel;
  logic          unused_rsvd;

  logic [NCH*DW-1:0]    gain_all, offs_all;
  logic [NCH*SLEWW-1:0] slew_all;

  qdac_spi_shifter #(.SYNC_STAGES(SYNC_STAGES), .FRAME_W(FW)) i_shifter (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .tx_word_i(tx_word), .miso_o(spi_miso), .cs_idle_o(cs_idle),
    .frame_vld_o(frame_vld), .frame_o(frame_bits)
  );

  // frame field split
  assign f_rd        = frame_bits[RD_BIT];
  assign f_addr      = frame_bits[ADDR_LSB +: AW];
  assign f_data      = frame_bits[DW-1:0];
  assign unused_rsvd = ^frame_bits[RD_BIT-1:ADDR_LSB+AW];
  assign f_grp       = f_addr[AW-1:CHW];
  assign f_ch        = f_addr[CHW-1:0];
  assign f_sel       = ctrl_sub_e'(f_data[DW-1:SEL_LSB]);
  assign wr_ok       = frame_vld & ~f_rd;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      logic hit;
      assign hit = wr_ok && (f_ch == CHW'(g));
      qdac_chan_bank #(.OFFSET_RST(OFFSET_RST)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .we_data_i(hit && (f_grp == WGRP_DATA)),
        .we_gain_i(hit && (f_grp == WGRP_GAIN)),
        .we_offs_i(hit && (f_grp == WGRP_OFFS)),
        .we_slew_i(hit && (f_grp == WGRP_CTRL) && (f_sel == SUB_SLEW)),
        .we_ctrl_i(hit && (f_grp == WGRP_CTRL) && (f_sel == SUB_DAC)),
        .wdata_i(f_data),
        .data_o(dac_code_o[g*DW +: DW]),
        .gain_o(gain_all[g*DW +: DW]),
        .offs_o(offs_all[g*DW +: DW]),
        .slew_o(slew_all[g*SLEWW +: SLEWW]),
        .ctrl_o(dac_ctrl_o[g*CTRLW +: CTRLW]),
        .current_o(ch_current_o[g])
      );
    end
  endgenerate

  // shared words: channel bits are ignored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_cfg_o <= '0;
      dcdc_cfg_o <= '0;
    end else if (wr_ok && (f_grp == WGRP_CTRL)) begin
      if (f_sel == SUB_MAIN) main_cfg_o <= f_data[MAINW-1:0];
      if (f_sel == SUB_DCDC) dcdc_cfg_o <= f_data[DCDCW-1:0];
    end
  end

  qdac_readback i_readback (
    .clk(clk), .rst_n(rst_n),
    .frame_vld_i(frame_vld), .frame_rd_i(f_rd), .frame_addr_i(f_addr),
    .data_all_i(dac_code_o), .gain_all_i(gain_all), .offs_all_i(offs_all),
    .slew_all_i(slew_all), .ctrl_all_i(dac_ctrl_o),
    .main_i(main_cfg_o), .dcdc_i(dcdc_cfg_o),
    .tx_word_o(tx_word)
  );
endmodule

// File: rtl/qdac_spi_regs_chk.sv
module qdac_spi_regs_chk
  import qdac_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_vld,
  input logic [FW-1:0]        frame_bits,
  input logic                 cs_idle,
  input logic [NCH*DW-1:0]    dac_code_o,
  input logic [NCH*CTRLW-1:0] dac_ctrl_o,
  input logic [MAINW-1:0]     main_cfg_o,
  input logic [DCDCW-1:0]     dcdc_cfg_o
);
  // R1
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);

  // R1
  frame_at_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> cs_idle);

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(dac_code_o));

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> ($stable(dac_ctrl_o) && $stable(main_cfg_o) && $stable(dcdc_cfg_o)));

  // R6
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && frame_bits[RD_BIT]) |=>
      ($stable(dac_code_o) && $stable(dac_ctrl_o) && $stable(main_cfg_o) && $stable(dcdc_cfg_o)));

  // R5
  noop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && (frame_bits == NOOP_FRAME)) |=>
      ($stable(dac_code_o) && $stable(dac_ctrl_o) && $stable(main_cfg_o) && $stable(dcdc_cfg_o)));
endmodule

bind qdac_spi_regs qdac_spi_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_bits(frame_bits),
  .cs_idle(cs_idle), .dac_code_o(dac_code_o), .dac_ctrl_o(dac_ctrl_o),
  .main_cfg_o(main_cfg_o), .dcdc_cfg_o(dcdc_cfg_o)
);

// File: tb/test_qdac_spi_regs.sv
module test_qdac_spi_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 6;
  localparam int WD_LIMIT   = 190000;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [63:0] dac_code;
  logic [35:0] dac_ctrl;
  logic [3:0]  ch_current;
  logic [12:0] main_cfg;
  logic [6:0]  dcdc_cfg;

  qdac_spi_regs i_qdac_spi_regs (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .dac_code_o(dac_code), .dac_ctrl_o(dac_ctrl),
    .ch_current_o(ch_current), .main_cfg_o(main_cfg), .dcdc_cfg_o(dcdc_cfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc++;

  // bench model
  logic [15:0] m_data[4], m_gain[4], m_offs[4];
  logic [12:0] m_slew[4];
  logic [8:0]  m_ctrl[4];
  logic [12:0] m_main;
  logic [6:0]  m_dcdc;
  logic [15:0] m_pend;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [4:0] a);
    int c = int'(a[1:0]);
    case (a[4:2])
      3'd0: return m_data[c];
      3'd1: return {7'h0, m_ctrl[c]};
      3'd2: return m_gain[c];
      3'd3: return m_offs[c];
      3'd5: return {3'h0, m_slew[c]};
      3'd6: begin
        if (c == 0) return {12'h0, m_ctrl[3][6], m_ctrl[2][6], m_ctrl[1][6], m_ctrl[0][6]};
        if (c == 1) return {3'h0, m_main};
        if (c == 2) return {9'h0, m_dcdc};
        return 16'h0;
      end
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_write(input logic [23:0] f);
    int c = int'(f[17:16]);
    logic [15:0] d = f[15:0];
    case (f[20:18])
      3'd0: m_data[c] = d;
      3'd2: m_gain[c] = d;
      3'd4: m_offs[c] = d;
      3'd7: case (d[15:13])
        3'd0: m_slew[c] = d[12:0];
        3'd1: m_main    = d[12:0];
        3'd2: m_ctrl[c] = d[8:0];
        3'd3: m_dcdc    = d[6:0];
        default: ;
      endcase
      default: ;
    endcase
  endtask

  task automatic check_outputs(input string req);
    logic [63:0] ec;
    logic [35:0] et;
    logic [3:0]  eu;
    for (int i = 0; i < 4; i++) begin
      ec[i*16 +: 16] = m_data[i];
      et[i*9 +: 9]   = m_ctrl[i];
      eu[i] = (m_ctrl[i][2:0] >= 3'd4) && (m_ctrl[i][2:0] <= 3'd6);
    end
    check({req, " R10 code"}, 64'(dac_code), ec);
    check({req, " R10 ctrl"}, 64'(dac_ctrl), 64'(et));
    check({req, " R10 current"}, 64'(ch_current), 64'(eu));
    check({req, " R12 main"}, 64'(main_cfg), 64'(m_main));
    check({req, " R12 dcdc"}, 64'(dcdc_cfg), 64'(m_dcdc));
  endtask

  task automatic xfer(input logic [23:0] f, input int nbits, input string req);
    logic [23:0] rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    check("R11 miso idle before clocks", 64'(miso), 64'(0) | 64'(m_pend[15] & 1'b0));
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? f[23-i] : 1'b0;
      repeat (HALF_SCLK) @(negedge clk);
      sclk = 1'b1;
      if (i < 24) rx[23-i] = miso;
      repeat (HALF_SCLK) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (10) @(negedge clk);
    if (nbits == 24) begin
      check({req, " R1 R7 echo"}, 64'(rx), 64'({8'h0, m_pend}));
      m_pend = f[23] ? model_read(f[20:16]) : 16'h0;
      if (!f[23]) model_write(f);
    end
    check_outputs(req);
    check("R11 miso deselected", 64'(miso), 64'(0));
  endtask

  initial begin
    wait (done || cyc >= WD_LIMIT);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_data[i] = 16'h0; m_gain[i] = 16'h0; m_offs[i] = 16'h8000;
      m_slew[i] = 13'h0; m_ctrl[i] = 9'h0;
    end
    m_main = 13'h0; m_dcdc = 7'h0; m_pend = 16'h0;

    repeat (5) @(negedge clk);
    check_outputs("R9 reset");
    check("R11 miso in reset", 64'(miso), 64'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // read every address from the reset state (R9 values via R6/R8 map)
    for (int a = 0; a < 32; a++) xfer({1'b1, 2'b0, 5'(a), 16'h0}, 24, "R6 R8 R9 read");
    xfer(24'h1CE000, 24, "R5 noop");

    // every non-control write address (R3)
    for (int a = 0; a < 28; a++)
      xfer({1'b0, 2'b0, 5'(a), 16'(16'h1357 * (a + 1)) ^ 16'h00F0}, 24, "R1 R3 write");

    // every selector on every channel (R4)
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 8; s++)
        xfer({1'b0, 2'b0, 5'(28 + c), 3'(s), 13'h0A5C ^ 13'(c * 37 + s * 211)}, 24, "R4 ctrl");

    for (int a = 0; a < 32; a++) xfer({1'b1, 2'b0, 5'(a), 16'h0}, 24, "R6 R8 read");
    xfer(24'h1CE000, 24, "R5 noop");
    xfer(24'h1CE000, 24, "R5 R7 noop after noop");

    // bad bit counts (R2), pending read must survive them
    xfer({1'b1, 2'b0, 5'h19, 16'h0}, 24, "R6 read main");
    xfer({1'b0, 2'b0, 5'h00, 16'hDEAD}, 23, "R2 short");
    xfer({1'b0, 2'b0, 5'h1D, 3'd2, 13'h0046}, 25, "R2 long");
    xfer({1'b0, 2'b0, 5'h1C, 3'd3, 13'h007F}, 1, "R2 one bit");
    xfer(24'h1CE000, 24, "R2 R7 pending kept");

    // every range code on every channel (R10)
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 8; r++)
        xfer({1'b0, 2'b0, 5'(28 + c), 3'd2, 4'h0, 2'b0, r[0], 1'b0, c[0], 1'b0, 3'(r)}, 24, "R10 range");

    xfer({1'b0, 2'b0, 5'h1E, 3'd2, 13'h0045}, 24, "R10 set out_en");
    for (int a = 4; a < 8; a++) xfer({1'b1, 2'b0, 5'(a), 16'h0}, 24, "R6 ctrl read");
    xfer({1'b1, 2'b0, 5'h18, 16'h0}, 24, "R8 status read");
    xfer({1'b1, 2'b0, 5'h1A, 16'h0}, 24, "R12 dcdc read");
    xfer(24'h1CE000, 24, "R7 final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule